// File: doc/BRIEF.md
# Operand-Format Add/Move Executor

This block carries out one decoded ADD or MOVE instruction at a time. It works on a register file, an accumulator and a synchronous data memory. The instruction's format code says how many explicit operands it carries. From that code the block picks the two sources and the destination:

- three-address: two sources and a separate destination;
- two-address: the second operand is both a source and the destination;
- one-and-half-address: a memory source and a register that is both a source and the destination;
- one-address: the accumulator is the hidden second source and the destination.

Each explicit operand comes with a kind bit (1 = memory, 0 = register) and an address field. A register uses the low bits of that field as its index.

Instructions enter on a valid/ready handshake. `in_ready` is high only while the block is idle. An instruction is taken on a cycle where both `in_valid` and `in_ready` are high. While the block is busy `in_ready` stays low, and the source must hold its instruction until it is taken. Register operands are read in one cycle. Each memory operand costs one extra cycle, because the memory has a registered read and allows one access per cycle. After the write, `done` pulses for one cycle, and the `res_*` pins describe the value written and where it went.

Top module: `xop_exec`

## Requirements
- R1: Format code 3'd0 (three-address) writes src1 + src2 into the third operand; each operand may independently be a register or a memory word.
- R2: Format code 3'd1 (two-address) writes src1 + src2 into the second operand and leaves the first operand unchanged; a MOVE then ADD into the same target leaves it equal to the sum of both moved-in values.
- R3: With `in_move` = 1 the destination receives the first source unchanged in every format, and the carry flag keeps its old value.
- R4: Format code 3'd2 (one-and-half) always treats operand one as a memory word and operand two as a register, whatever their kind bits; the register receives mem + reg.
- R5: Format code 3'd3 (one-address) adds operand one to the accumulator and writes the accumulator; no other format changes the accumulator.
- R6: ADD wraps modulo 2^DW, and `carry` takes the carry-out of every ADD.
- R7: Format codes 3'd4 to 3'd7 are accepted, raise `illegal` for exactly the next cycle, produce no `done`, and change no register, memory word, accumulator or carry.
- R8: `in_ready` is high only when idle and low the cycle after a legal instruction is taken. `done` is a one-cycle pulse. With it, `res_data` holds the written value, `res_is_mem`/`res_is_acc` give the destination kind, and `res_addr` gives the destination's address field (0 for the accumulator).
- R9: `done` is seen 4 clock edges after the accepting edge (the accepting edge counts as the first), plus one edge for each memory read. The reads counted are a memory first source, and a memory second source of an ADD.
- R10: After reset, register i holds REG_STEP*(i+1) mod 2^DW, the accumulator and carry are 0, `in_ready` is 1, and `done` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction will be taken |
| in_fmt | input | 3 | Format code |
| in_move | input | 1 | 1 = MOVE, 0 = ADD |
| in_a_mem | input | 1 | Operand one is memory |
| in_a_addr | input | MAW | Operand one address / register index |
| in_b_mem | input | 1 | Operand two is memory |
| in_b_addr | input | MAW | Operand two address / register index |
| in_c_mem | input | 1 | Operand three is memory |
| in_c_addr | input | MAW | Operand three address / register index |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for a rejected format code |
| res_data | output | DW | Value of the last write |
| res_is_mem | output | 1 | Last write went to memory |
| res_is_acc | output | 1 | Last write went to the accumulator |
| res_addr | output | MAW | Address field of the last destination |
| carry | output | 1 | Carry-out of the last ADD |
| acc | output | DW | Accumulator contents |

## Verification
The bench builds the block with its defaults: DW = 16, eight registers, 256 memory words and REG_STEP = 16'h1357. That step value sets the upper registers near the top of the 16-bit range, so adding R6 and R7 wraps and drives the carry. The 256-word memory gives room for separate scratch locations well away from the register index range. Memory words are filled with MOVEs before they are read. Register contents are brought out by MOVEing a register onto itself and reading `res_data`.

// File: rtl/xop_pkg.sv
package xop_pkg;
  typedef enum logic [1:0] {OPK_REG = 2'd0, OPK_MEM = 2'd1, OPK_ACC = 2'd2} opk_t;
  typedef enum logic [2:0] {
    FMT_THREE = 3'd0, FMT_TWO = 3'd1, FMT_ONEHALF = 3'd2, FMT_ONE = 3'd3
  } fmt_t;
  typedef enum logic [2:0] {
    S_IDLE, S_OPA, S_OPA_W, S_OPB, S_OPB_W, S_WB
  } xst_t;
endpackage

// File: rtl/xop_route.sv
module xop_route
  import xop_pkg::*;
#(
  parameter int MAW = 8
) (
  input  logic [2:0]     fmt,
  input  logic           a_mem,
  input  logic [MAW-1:0] a_addr,
  input  logic           b_mem,
  input  logic [MAW-1:0] b_addr,
  input  logic           c_mem,
  input  logic [MAW-1:0] c_addr,
  output logic           fmt_ok,
  output opk_t           sa_kind,
  output logic [MAW-1:0] sa_addr,
  output opk_t           sb_kind,
  output logic [MAW-1:0] sb_addr,
  output opk_t           d_kind,
  output logic [MAW-1:0] d_addr
);
  opk_t ka, kb, kc;
  assign ka = a_mem ? OPK_MEM : OPK_REG;
  assign kb = b_mem ? OPK_MEM : OPK_REG;
  assign kc = c_mem ? OPK_MEM : OPK_REG;

  always_comb begin
    fmt_ok  = 1'b1;
    sa_kind = ka;  sa_addr = a_addr;
    sb_kind = kb;  sb_addr = b_addr;
    d_kind  = kc;  d_addr  = c_addr;
    case (fmt)
      FMT_THREE: ;
      FMT_TWO: begin
        d_kind = kb;  d_addr = b_addr;
      end
      FMT_ONEHALF: begin
        sa_kind = OPK_MEM;
        sb_kind = OPK_REG;
        d_kind  = OPK_REG;  d_addr = b_addr;
      end
      FMT_ONE: begin
        sb_kind = OPK_ACC;  sb_addr = '0;
        d_kind  = OPK_ACC;  d_addr  = '0;
      end
      default: fmt_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/xop_regfile.sv
module xop_regfile #(
  parameter int DW       = 16,
  parameter int NREG     = 8,
  parameter int REG_STEP = 32'h1357,
  localparam int RAW     = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] rd_idx,
  output logic [DW-1:0]  rd_data,
  input  logic           we,
  input  logic [RAW-1:0] wr_idx,
  input  logic [DW-1:0]  wr_data
);
  logic [DW-1:0] r_q [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n)
        r_q[i] <= DW'(REG_STEP * (i + 1));
      else if (we && wr_idx == RAW'(i))
        r_q[i] <= wr_data;
    end
  end

  assign rd_data = r_q[rd_idx];
endmodule

// File: rtl/xop_dmem.sv
module xop_dmem #(
  parameter int DW     = 16,
  parameter int MDEPTH = 256,
  localparam int MAW   = $clog2(MDEPTH)
) (
  input  logic           clk,
  input  logic [MAW-1:0] addr,
  input  logic           we,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] m_q [MDEPTH];

  always_ff @(posedge clk) begin
    if (we) m_q[addr] <= wdata;
    rdata <= m_q[addr];
  end
endmodule

// File: rtl/xop_exec.sv
module xop_exec
  import xop_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NREG     = 8,
  parameter int MDEPTH   = 256,
  parameter int REG_STEP = 32'h1357,
  localparam int RAW     = $clog2(NREG),
  localparam int MAW     = $clog2(MDEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2:0]     in_fmt,
  input  logic           in_move,
  input  logic           in_a_mem,
  input  logic [MAW-1:0] in_a_addr,
  input  logic           in_b_mem,
  input  logic [MAW-1:0] in_b_addr,
  input  logic           in_c_mem,
  input  logic [MAW-1:0] in_c_addr,
  output logic           done,
  output logic           illegal,
  output logic [DW-1:0]  res_data,
  output logic           res_is_mem,
  output logic           res_is_acc,
  output logic [MAW-1:0] res_addr,
  output logic           carry,
  output logic [DW-1:0]  acc
);
  xst_t state_q;
  logic mv_q;
  opk_t sa_kind_q, sb_kind_q, d_kind_q;
  logic [MAW-1:0] sa_addr_q, sb_addr_q, d_addr_q;
  logic [DW-1:0] opa_q, opb_q, acc_q;
  logic carry_q;

  // operand routing on the offered instruction
  logic fmt_ok;
  opk_t sa_kind, sb_kind, d_kind;
  logic [MAW-1:0] sa_addr, sb_addr, d_addr;

  xop_route #(.MAW(MAW)) u_route (
    .fmt(in_fmt), .a_mem(in_a_mem), .a_addr(in_a_addr),
    .b_mem(in_b_mem), .b_addr(in_b_addr), .c_mem(in_c_mem), .c_addr(in_c_addr),
    .fmt_ok(fmt_ok), .sa_kind(sa_kind), .sa_addr(sa_addr),
    .sb_kind(sb_kind), .sb_addr(sb_addr), .d_kind(d_kind), .d_addr(d_addr)
  );

  // adder / move result
  logic [DW:0]   sum_w;
  logic [DW-1:0] result;
  assign sum_w  = {1'b0, opa_q} + {1'b0, opb_q};
  assign result = mv_q ? opa_q : sum_w[DW-1:0];

  // register file port
  logic [RAW-1:0] rf_rd_idx;
  logic [DW-1:0]  rf_rdata;
  logic           rf_we;
  assign rf_rd_idx = (state_q == S_OPA) ? sa_addr_q[RAW-1:0] : sb_addr_q[RAW-1:0];
  assign rf_we     = (state_q == S_WB) && (d_kind_q == OPK_REG);

  xop_regfile #(.DW(DW), .NREG(NREG), .REG_STEP(REG_STEP)) u_rf (
    .clk(clk), .rst_n(rst_n), .rd_idx(rf_rd_idx), .rd_data(rf_rdata),
    .we(rf_we), .wr_idx(d_addr_q[RAW-1:0]), .wr_data(result)
  );

  // data memory: one access per cycle, address chosen by phase
  logic [MAW-1:0] mem_addr;
  logic           mem_we;
  logic [DW-1:0]  mem_rdata;
  always_comb begin
    case (state_q)
      S_OPA:   mem_addr = sa_addr_q;
      S_OPB:   mem_addr = sb_addr_q;
      default: mem_addr = d_addr_q;
    endcase
  end
  assign mem_we = (state_q == S_WB) && (d_kind_q == OPK_MEM);

  xop_dmem #(.DW(DW), .MDEPTH(MDEPTH)) u_mem (
    .clk(clk), .addr(mem_addr), .we(mem_we), .wdata(result), .rdata(mem_rdata)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      mv_q       <= 1'b0;
      sa_kind_q  <= OPK_REG;  sb_kind_q <= OPK_REG;  d_kind_q <= OPK_REG;
      sa_addr_q  <= '0;       sb_addr_q <= '0;       d_addr_q <= '0;
      opa_q      <= '0;       opb_q     <= '0;
      acc_q      <= '0;
      carry_q    <= 1'b0;
      done       <= 1'b0;
      illegal    <= 1'b0;
      res_data   <= '0;
      res_is_mem <= 1'b0;
      res_is_acc <= 1'b0;
      res_addr   <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      case (state_q)
        S_IDLE: if (in_valid) begin
          if (fmt_ok) begin
            mv_q      <= in_move;
            sa_kind_q <= sa_kind;  sa_addr_q <= sa_addr;
            sb_kind_q <= sb_kind;  sb_addr_q <= sb_addr;
            d_kind_q  <= d_kind;   d_addr_q  <= d_addr;
            state_q   <= S_OPA;
          end else begin
            illegal <= 1'b1;
          end
        end
        S_OPA: begin
          if (sa_kind_q == OPK_MEM) state_q <= S_OPA_W;
          else begin
            opa_q   <= rf_rdata;
            state_q <= S_OPB;
          end
        end
        S_OPA_W: begin
          opa_q   <= mem_rdata;
          state_q <= S_OPB;
        end
        S_OPB: begin
          if (mv_q) state_q <= S_WB;
          else begin
            case (sb_kind_q)
              OPK_MEM: state_q <= S_OPB_W;
              OPK_ACC: begin opb_q <= acc_q;    state_q <= S_WB; end
              default: begin opb_q <= rf_rdata; state_q <= S_WB; end
            endcase
          end
        end
        S_OPB_W: begin
          opb_q   <= mem_rdata;
          state_q <= S_WB;
        end
        S_WB: begin
          if (d_kind_q == OPK_ACC) acc_q <= result;
          if (!mv_q) carry_q <= sum_w[DW];
          res_data   <= result;
          res_is_mem <= (d_kind_q == OPK_MEM);
          res_is_acc <= (d_kind_q == OPK_ACC);
          res_addr   <= d_addr_q;
          done       <= 1'b1;
          state_q    <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign in_ready = (state_q == S_IDLE);
  assign acc      = acc_q;
  assign carry    = carry_q;
endmodule

// File: rtl/xop_exec_chk.sv
module xop_exec_chk
  import xop_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_fmt,
  input logic          done,
  input logic          illegal,
  input logic [DW-1:0] acc,
  input logic          carry,
  input xst_t          state_q,
  input logic          mv_q,
  input opk_t          d_kind_q
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_fmt <= 3'd3) |=> !in_ready);

  a_r8_done_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  a_r7_illegal_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_fmt > 3'd3) |=>
      (illegal && in_ready && !done && $stable(acc) && $stable(carry)));

  a_r3_move_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WB && mv_q) |=> $stable(carry));

  a_r5_acc_only_one_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_q == S_WB && d_kind_q == OPK_ACC) |=> $stable(acc));
endmodule

bind xop_exec xop_exec_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_xop_exec.sv
module tb_xop_exec;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, NREG = 8, MDEPTH = 256, STEP = 32'h1357;
  localparam int MAW = $clog2(MDEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, in_move = 1'b0;
  logic [2:0] in_fmt = '0;
  logic in_a_mem = 1'b0, in_b_mem = 1'b0, in_c_mem = 1'b0;
  logic [MAW-1:0] in_a_addr = '0, in_b_addr = '0, in_c_addr = '0;
  logic done, illegal, res_is_mem, res_is_acc, carry;
  logic [DW-1:0] res_data, acc;
  logic [MAW-1:0] res_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  xop_exec #(.DW(DW), .NREG(NREG), .MDEPTH(MDEPTH), .REG_STEP(STEP)) dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] m_reg [NREG];
  logic [DW-1:0] m_mem [MDEPTH];
  logic [DW-1:0] m_acc;
  logic          m_carry;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // vector: [30:28] fmt, [27] move, [26] a_mem, [25:18] a, [17] b_mem, [16:9] b, [8] c_mem, [7:0] c
  localparam int NV = 16;
  localparam logic [30:0] VEC [NV] = '{
    {3'd1, 1'b1, 1'b0, 8'd1,  1'b1, 8'd10, 1'b0, 8'd0 },  // MOVE R1 -> M10
    {3'd1, 1'b1, 1'b0, 8'd6,  1'b1, 8'd20, 1'b0, 8'd0 },  // MOVE R6 -> M20
    {3'd0, 1'b0, 1'b0, 8'd0,  1'b0, 8'd1,  1'b0, 8'd2 },  // R0+R1 -> R2
    {3'd0, 1'b0, 1'b1, 8'd10, 1'b0, 8'd3,  1'b1, 8'd30},  // M10+R3 -> M30
    {3'd0, 1'b0, 1'b1, 8'd10, 1'b1, 8'd20, 1'b0, 8'd4 },  // M10+M20 -> R4
    {3'd1, 1'b0, 1'b0, 8'd6,  1'b0, 8'd7,  1'b0, 8'd0 },  // R6+R7 -> R7 (wraps)
    {3'd1, 1'b0, 1'b1, 8'd20, 1'b1, 8'd30, 1'b0, 8'd0 },  // M20+M30 -> M30
    {3'd1, 1'b1, 1'b1, 8'd10, 1'b0, 8'd5,  1'b0, 8'd0 },  // MOVE M10 -> R5
    {3'd1, 1'b0, 1'b0, 8'd2,  1'b0, 8'd5,  1'b0, 8'd0 },  // ADD R2,R5
    {3'd2, 1'b0, 1'b0, 8'd20, 1'b1, 8'd3,  1'b1, 8'd99},  // one-and-half, kinds ignored
    {3'd3, 1'b0, 1'b0, 8'd4,  1'b0, 8'd0,  1'b0, 8'd0 },  // acc += R4
    {3'd3, 1'b0, 1'b1, 8'd30, 1'b0, 8'd0,  1'b0, 8'd0 },  // acc += M30
    {3'd3, 1'b1, 1'b1, 8'd20, 1'b0, 8'd0,  1'b0, 8'd0 },  // acc <= M20
    {3'd0, 1'b1, 1'b0, 8'd7,  1'b1, 8'd50, 1'b1, 8'd40},  // three-addr MOVE R7 -> M40
    {3'd3, 1'b0, 1'b1, 8'd40, 1'b0, 8'd0,  1'b0, 8'd0 },  // acc += M40
    {3'd2, 1'b1, 1'b1, 8'd40, 1'b0, 8'd6,  1'b0, 8'd0 }   // MOVE M40 -> R6
  };

  task automatic run(input logic [2:0] f, input logic mv, input logic am, input logic [7:0] aa,
                     input logic bm, input logic [7:0] ba, input logic cm, input logic [7:0] ca,
                     input string req);
    logic sam, sbm, sbacc, dm, dacc;
    logic [7:0] sa, sb, da;
    logic [DW-1:0] va, vb, vr;
    logic [DW:0] s;
    logic ecar;
    int reads, cyc;
    sam = am; sa = aa; sbm = bm; sb = ba; sbacc = 1'b0; dm = cm; dacc = 1'b0; da = ca;
    case (f)
      3'd1: begin dm = bm; da = ba; end
      3'd2: begin sam = 1'b1; sbm = 1'b0; dm = 1'b0; da = ba; end
      3'd3: begin sbacc = 1'b1; sbm = 1'b0; dm = 1'b0; dacc = 1'b1; da = 8'd0; end
      default: ;
    endcase
    va = sam ? m_mem[sa] : m_reg[sa[2:0]];
    vb = sbacc ? m_acc : (sbm ? m_mem[sb] : m_reg[sb[2:0]]);
    s  = {1'b0, va} + {1'b0, vb};
    vr = mv ? va : s[DW-1:0];
    ecar  = mv ? m_carry : s[DW];
    reads = int'(sam) + int'(!mv && sbm);

    @(negedge clk);
    in_valid = 1'b1; in_fmt = f; in_move = mv;
    in_a_mem = am; in_a_addr = aa; in_b_mem = bm; in_b_addr = ba; in_c_mem = cm; in_c_addr = ca;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 1;
    chk("R8", "ready low while busy", 32'(in_ready), 32'd0);
    while (!done && cyc < 40) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
    chk(req, "res_data", 32'(res_data), 32'(vr));
    chk("R8", "res_is_mem", 32'(res_is_mem), 32'(dm));
    chk("R8", "res_is_acc", 32'(res_is_acc), 32'(dacc));
    chk("R8", "res_addr", 32'(res_addr), 32'(da));
    chk(mv ? "R3" : "R6", "carry", 32'(carry), 32'(ecar));
    chk("R9", "latency", 32'(cyc), 32'(4 + reads));
    // model update
    if (dacc) m_acc = vr;
    else if (dm) m_mem[da] = vr;
    else m_reg[da[2:0]] = vr;
    m_carry = ecar;
    chk("R5", "acc", 32'(acc), 32'(m_acc));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) m_reg[i] = DW'(STEP * (i + 1));
    m_acc = '0; m_carry = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "in_ready", 32'(in_ready), 32'd1);
    chk("R10", "done", 32'(done), 32'd0);
    chk("R10", "illegal", 32'(illegal), 32'd0);
    chk("R10", "acc", 32'(acc), 32'd0);
    chk("R10", "carry", 32'(carry), 32'd0);
    for (int i = 0; i < NREG; i++)
      run(3'd1, 1'b1, 1'b0, 8'(i), 1'b0, 8'(i), 1'b0, 8'd0, "R10");

    // table walk: R1, R2, R3, R4, R5, R6
    for (int k = 0; k < NV; k++) begin
      logic [30:0] v;
      string tag;
      v = VEC[k];
      if (v[27]) tag = "R3";
      else case (v[30:28])
        3'd0: tag = "R1";
        3'd1: tag = "R2";
        3'd2: tag = "R4";
        default: tag = "R5";
      endcase
      run(v[30:28], v[27], v[26], v[25:18], v[17], v[16:9], v[8], v[7:0], tag);
    end

    // R2: first operand survives a two-address add
    run(3'd1, 1'b0, 1'b0, 8'd0, 1'b0, 8'd1, 1'b0, 8'd0, "R2");
    run(3'd1, 1'b1, 1'b0, 8'd0, 1'b0, 8'd0, 1'b0, 8'd0, "R2");

    // R7: illegal format codes
    for (int f = 4; f < 8; f++) begin
      logic [DW-1:0] acc0;
      logic car0;
      acc0 = acc; car0 = carry;
      @(negedge clk);
      in_valid = 1'b1; in_fmt = 3'(f); in_move = 1'b0;
      in_a_mem = 1'b0; in_a_addr = 8'd3; in_b_mem = 1'b0; in_b_addr = 8'd2;
      in_c_mem = 1'b0; in_c_addr = 8'd2;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R7", "illegal pulse", 32'(illegal), 32'd1);
      chk("R7", "no done", 32'(done), 32'd0);
      chk("R7", "still ready", 32'(in_ready), 32'd1);
      @(negedge clk);
      chk("R7", "illegal cleared", 32'(illegal), 32'd0);
      chk("R7", "acc kept", 32'(acc), 32'(acc0));
      chk("R7", "carry kept", 32'(carry), 32'(car0));
    end
    // R7: targeted register unchanged
    run(3'd1, 1'b1, 1'b0, 8'd2, 1'b0, 8'd2, 1'b0, 8'd0, "R7");

    @(negedge clk);
    chk("R8", "done is single pulse", 32'(done), 32'd0);
    summary();
    $finish;
  end
endmodule